// File: doc/BRIEF.md
# Flash Program and Erase Completion Poller

This block sits on the host side of a byte-wide parallel flash device and carries out one alteration at a time: a single-byte program, an erase of the sector that holds a given address, or an erase of the whole chip. A request carries an operation code, a polling method, an address and a data byte, and is taken on a valid/ready handshake. The block then plays out the unlock and command write cycles with a strobe of guaranteed width. After the final strobe it reads the target address over and over until the device's embedded status shows that the operation has finished.

Two completion methods can be chosen for each request. In complement polling, bit 7 of a read is compared with the value expected when the device is idle: the written bit 7 for a program, and 1 for an erase. In toggle detection, bit 6 of consecutive reads is compared, and the device counts as idle once it stops alternating. A bounded poll count guards against a device that never finishes. When that count runs out, one confirming read decides whether the result is done or error. The unlock addresses, unlock data and command bytes are parameters.

Top module: `flash_op_poller`

## Requirements
- R1: For req_op 2'b00 (program), exactly four writes are issued in this order: (UNL_ADDR_A, UNL_DATA_A), (UNL_ADDR_B, UNL_DATA_B), (UNL_ADDR_A, CMD_PROGRAM), (req_addr, req_data).
- R2: For req_op 2'b01 (sector erase) and 2'b1x (chip erase), exactly six writes are issued: (A,DA), (B,DB), (A,CMD_ERASE), (A,DA), (B,DB), and then (req_addr, CMD_SECTOR) for a sector erase or (UNL_ADDR_A, CMD_CHIP) for a chip erase.
- R3: For each write, fl_we_n is low for STB cycles with fl_ce_n low and fl_wdrive high. STB is the larger of STROBE_CYC and the smallest cycle count whose length exceeds 5 ns at CLK_PERIOD_NS. Between writes, fl_we_n stays high for HOLD_CYC cycles.
- R4: No read begins before the last write strobe of the sequence has ended. Each read holds fl_oe_n low for READ_CYC cycles at the target address, and reads are separated by one cycle with fl_oe_n high.
- R5: In polling mode (req_toggle=0), a program is complete on the first read whose bit 7 equals bit 7 of req_data.
- R6: In polling mode, an erase is complete on the first read whose bit 7 is 1.
- R7: In toggle mode (req_toggle=1), an operation is complete on the first read whose bit 6 equals bit 6 of the previous read of the same operation. The first read never completes.
- R8: After TIMEOUT_POLLS reads that do not complete, exactly one further read is made. If that read completes, done is reported; otherwise err is reported. At most TIMEOUT_POLLS+1 reads are made.
- R9: done or err pulses for one cycle. The pulse falls in the cycle in which fl_oe_n returns high after the deciding read, and last_read then holds that read's byte. The two never pulse together.
- R10: req_ready is high only while idle. A request is taken when req_valid and req_ready are both high, req_ready drops the next cycle, req_valid pulses while req_ready is low have no effect, and req_ready returns the cycle after done or err.
- R11: While reset is asserted, req_ready is high, fl_ce_n, fl_we_n and fl_oe_n are high, and fl_wdrive, done and err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 2 | 00 program, 01 sector erase, 1x chip erase |
| req_toggle | input | 1 | 0 complement polling, 1 toggle detection |
| req_addr | input | ADDR_W | Target byte or sector address |
| req_data | input | 8 | Byte to program |
| done | output | 1 | One-cycle pulse: operation finished |
| err | output | 1 | One-cycle pulse: no completion after the confirming read |
| last_read | output | 8 | Byte returned by the most recent status read |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_wdata | output | 8 | Data driven to the flash during writes |
| fl_wdrive | output | 1 | High while fl_wdata should drive the data bus |
| fl_rdata | input | 8 | Data read from the flash |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |

## Verification
The first strobe falls in the cycle after the request is taken. Every status read then returns its byte on the last of its READ_CYC low cycles, and done or err follows in the very next cycle, which is the one where fl_oe_n is back high. The bench waits on done or err one cycle at a time and, at the cycle where a pulse is first seen, checks that fl_oe_n was low in the cycle before, so that an extra or missing register stage shows up. A flash model records each strobe's address, data and width, and also counts the reads, so that the number of polls, the result, the returned byte and req_ready one cycle later are all compared against values worked out from the table.

// File: rtl/flash_op_poller.sv
module flash_op_poller #(
  parameter int ADDR_W        = 19,
  parameter int CLK_PERIOD_NS = 20,
  parameter int STROBE_CYC    = 2,
  parameter int HOLD_CYC      = 1,
  parameter int READ_CYC      = 2,
  parameter int TIMEOUT_POLLS = 4096,
  parameter logic [ADDR_W-1:0] UNL_ADDR_A = 'h5555,
  parameter logic [ADDR_W-1:0] UNL_ADDR_B = 'h2AAA,
  parameter logic [7:0] UNL_DATA_A  = 8'hAA,
  parameter logic [7:0] UNL_DATA_B  = 8'h55,
  parameter logic [7:0] CMD_PROGRAM = 8'hA0,
  parameter logic [7:0] CMD_ERASE   = 8'h80,
  parameter logic [7:0] CMD_SECTOR  = 8'h30,
  parameter logic [7:0] CMD_CHIP    = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic              req_toggle,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  output logic              done,
  output logic              err,
  output logic [7:0]        last_read,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  output logic              fl_wdrive,
  input  logic [7:0]        fl_rdata,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n
);

  localparam int MIN_STB = 5 / CLK_PERIOD_NS + 1;
  localparam int STB  = (STROBE_CYC > MIN_STB) ? STROBE_CYC : MIN_STB;
  localparam int HLD  = (HOLD_CYC > 1) ? HOLD_CYC : 1;
  localparam int RDC  = (READ_CYC > 1) ? READ_CYC : 1;
  localparam int TPL  = (TIMEOUT_POLLS > 1) ? TIMEOUT_POLLS : 1;
  localparam int CM1  = (STB > HLD) ? STB : HLD;
  localparam int CMAX = (CM1 > RDC) ? CM1 : RDC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int TW   = $clog2(TPL + 1);

  typedef enum logic [2:0] {S_IDLE, S_WLO, S_WHI, S_RD, S_GAP, S_RPT} st_t;

  st_t              state;
  logic [CW-1:0]    cnt;
  logic [2:0]       widx;
  logic [1:0]       op_q;
  logic             tog_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]       data_q;
  logic [TW-1:0]    polls;
  logic             confirm;
  logic             have_prev;
  logic             prev6;
  logic [7:0]       rd_q;
  logic             err_q;

  logic              is_prog, is_chip, rd_ok;
  logic [2:0]        last_w;
  logic [ADDR_W-1:0] w_addr;
  logic [7:0]        w_data;

  assign is_prog = (op_q == 2'b00);
  assign is_chip = op_q[1];
  assign last_w  = is_prog ? 3'd3 : 3'd5;

  always_comb begin
    w_addr = UNL_ADDR_A;
    w_data = UNL_DATA_A;
    case (widx)
      3'd1, 3'd4: begin
        w_addr = UNL_ADDR_B;
        w_data = UNL_DATA_B;
      end
      3'd2: w_data = is_prog ? CMD_PROGRAM : CMD_ERASE;
      3'd3: if (is_prog) begin
        w_addr = addr_q;
        w_data = data_q;
      end
      3'd5: begin
        w_addr = is_chip ? UNL_ADDR_A : addr_q;
        w_data = is_chip ? CMD_CHIP : CMD_SECTOR;
      end
      default: ;
    endcase
  end

  assign rd_ok = tog_q   ? (have_prev && (fl_rdata[6] == prev6)) :
                 is_prog ? (fl_rdata[7] == data_q[7]) : fl_rdata[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      widx      <= '0;
      op_q      <= '0;
      tog_q     <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      polls     <= '0;
      confirm   <= 1'b0;
      have_prev <= 1'b0;
      prev6     <= 1'b0;
      rd_q      <= '0;
      err_q     <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          op_q   <= req_op;
          tog_q  <= req_toggle;
          addr_q <= req_addr;
          data_q <= req_data;
          widx   <= '0;
          cnt    <= '0;
          state  <= S_WLO;
        end
        S_WLO: begin
          if (cnt == CW'(STB - 1)) begin
            cnt   <= '0;
            state <= S_WHI;
          end else cnt <= cnt + 1'b1;
        end
        S_WHI: begin
          if (cnt == CW'(HLD - 1)) begin
            cnt <= '0;
            if (widx == last_w) begin
              polls     <= '0;
              confirm   <= 1'b0;
              have_prev <= 1'b0;
              state     <= S_RD;
            end else begin
              widx  <= widx + 3'd1;
              state <= S_WLO;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_RD: begin
          if (cnt == CW'(RDC - 1)) begin
            cnt       <= '0;
            rd_q      <= fl_rdata;
            prev6     <= fl_rdata[6];
            have_prev <= 1'b1;
            if (rd_ok) begin
              err_q <= 1'b0;
              state <= S_RPT;
            end else if (confirm) begin
              err_q <= 1'b1;
              state <= S_RPT;
            end else begin
              if (polls == TW'(TPL - 1)) confirm <= 1'b1;
              polls <= polls + 1'b1;
              state <= S_GAP;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_GAP: state <= S_RD;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign done      = (state == S_RPT) && !err_q;
  assign err       = (state == S_RPT) && err_q;
  assign last_read = rd_q;
  assign fl_we_n   = !(state == S_WLO);
  assign fl_oe_n   = !(state == S_RD);
  assign fl_ce_n   = !((state == S_WLO) || (state == S_RD));
  assign fl_wdrive = (state == S_WLO) || (state == S_WHI);
  assign fl_addr   = ((state == S_RD) || (state == S_GAP)) ? addr_q : w_addr;
  assign fl_wdata  = w_data;

  assert_accept_drops_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_ready_after_report_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |=> req_ready);

  assert_single_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err}));

  assert_read_after_last_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_oe_n) |-> (widx == last_w));

  assert_strobe_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (STB > 1 && $fell(fl_we_n)) |=> !fl_we_n);

  assert_poll_program_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !tog_q && is_prog) |-> (last_read[7] == data_q[7]));

  assert_poll_erase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !tog_q && !is_prog) |-> last_read[7]);

endmodule

// File: tb/sim_flash_op_poller.sv
module sim_flash_op_poller;
  localparam int AW = 19;
  localparam int T  = 6;
  localparam logic [AW-1:0] UA = 19'h05555;
  localparam logic [AW-1:0] UB = 19'h02AAA;

  typedef struct packed {
    logic [1:0]    op;
    logic          tog;
    logic [AW-1:0] addr;
    logic [7:0]    data;
    logic [7:0]    k;
    logic [7:0]    ereads;
    logic          eerr;
    logic [7:0]    elast;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 19'h01234, 8'hA5, 8'd3,  8'd4, 1'b0, 8'hA5},
    '{2'd0, 1'b0, 19'h00042, 8'h3C, 8'd0,  8'd1, 1'b0, 8'h3C},
    '{2'd1, 1'b0, 19'h7F000, 8'h00, 8'd2,  8'd3, 1'b0, 8'hFF},
    '{2'd3, 1'b0, 19'h00000, 8'h00, 8'd6,  8'd7, 1'b0, 8'hFF},
    '{2'd0, 1'b0, 19'h00100, 8'h81, 8'd7,  8'd7, 1'b1, 8'h40},
    '{2'd0, 1'b1, 19'h00200, 8'h00, 8'd3,  8'd5, 1'b0, 8'h00},
    '{2'd1, 1'b1, 19'h31000, 8'h00, 8'd2,  8'd4, 1'b0, 8'hFF},
    '{2'd2, 1'b1, 19'h00000, 8'h00, 8'd10, 8'd7, 1'b1, 8'h40},
    '{2'd0, 1'b1, 19'h00300, 8'h00, 8'd2,  8'd3, 1'b0, 8'h00},
    '{2'd0, 1'b0, 19'h00400, 8'h7E, 8'd6,  8'd7, 1'b0, 8'h7E},
    '{2'd1, 1'b0, 19'h12000, 8'h00, 8'd9,  8'd7, 1'b1, 8'h40}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0;
  logic [1:0]    req_op = '0;
  logic          req_toggle = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic          req_ready, done, err, fl_wdrive, fl_ce_n, fl_oe_n, fl_we_n;
  logic [7:0]    last_read, fl_wdata, fl_rdata;
  logic [AW-1:0] fl_addr;

  flash_op_poller #(
    .ADDR_W(AW), .CLK_PERIOD_NS(20), .STROBE_CYC(3), .HOLD_CYC(1), .READ_CYC(2),
    .TIMEOUT_POLLS(T), .UNL_ADDR_A(UA), .UNL_ADDR_B(UB)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_toggle(req_toggle), .req_addr(req_addr), .req_data(req_data),
    .done(done), .err(err), .last_read(last_read), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_wdrive(fl_wdrive), .fl_rdata(fl_rdata),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  logic          v1_valid = 1'b0;
  logic          v1_ready, v1_done, v1_err, v1_wdrive, v1_ce_n, v1_oe_n, v1_we_n;
  logic [7:0]    v1_last, v1_wdata;
  logic [AW-1:0] v1_addr;

  flash_op_poller #(
    .ADDR_W(AW), .CLK_PERIOD_NS(2), .STROBE_CYC(1), .HOLD_CYC(1), .READ_CYC(2),
    .TIMEOUT_POLLS(2)
  ) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(v1_valid), .req_ready(v1_ready),
    .req_op(2'b00), .req_toggle(1'b0), .req_addr('0), .req_data(8'h00),
    .done(v1_done), .err(v1_err), .last_read(v1_last), .fl_addr(v1_addr),
    .fl_wdata(v1_wdata), .fl_wdrive(v1_wdrive), .fl_rdata(8'h00),
    .fl_ce_n(v1_ce_n), .fl_oe_n(v1_oe_n), .fl_we_n(v1_we_n)
  );

  int   n_tests = 0;
  int   n_fail  = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // flash model
  logic          m_clear = 1'b1;
  int            m_busy = 0;
  int            m_expw = 4;
  logic [7:0]    m_final = '0;
  logic          m_prog = 1'b1;
  int            m_reads, m_nw, wl, oel, oe_bad, early, clash;
  logic          pwe, poe;
  logic [AW-1:0] cur_a;
  logic [7:0]    cur_d;
  logic [AW-1:0] log_a [8];
  logic [7:0]    log_d [8];
  int            log_w [8];

  function automatic logic [7:0] dev_byte(input int i, input int busy, input logic [7:0] fin, input logic prog);
    if (i <= busy) return {(prog ? ~fin[7] : 1'b0), i[0], 6'b0};
    return fin;
  endfunction

  assign fl_rdata = dev_byte(m_reads, m_busy, m_final, m_prog);

  always @(posedge clk) begin
    if (m_clear) begin
      m_reads <= 0; m_nw <= 0; wl <= 0; oel <= 0; oe_bad <= 0;
      early <= 0; clash <= 0; pwe <= 1'b1; poe <= 1'b1;
    end else begin
      pwe <= fl_we_n;
      poe <= fl_oe_n;
      if (!fl_we_n) begin
        wl    <= wl + 1;
        cur_a <= fl_addr;
        cur_d <= fl_wdata;
      end else if (!pwe) begin
        if (m_nw < 8) begin
          log_a[m_nw] <= cur_a;
          log_d[m_nw] <= cur_d;
          log_w[m_nw] <= wl;
        end
        m_nw <= m_nw + 1;
        wl   <= 0;
      end
      if (!fl_oe_n) begin
        oel <= oel + 1;
        if (poe) begin
          m_reads <= m_reads + 1;
          if (m_nw < m_expw || !pwe) early <= early + 1;
        end
        if (fl_wdrive) clash <= clash + 1;
      end else if (!poe) begin
        if (oel != 2) oe_bad <= oe_bad + 1;
        oel <= 0;
      end
    end
  end

  function automatic logic [AW-1:0] exp_wa(input logic [1:0] op, input int i, input logic [AW-1:0] a);
    if (i == 1 || i == 4) return UB;
    if (op == 2'b00 && i == 3) return a;
    if (i == 5 && op == 2'b01) return a;
    return UA;
  endfunction

  function automatic logic [7:0] exp_wd(input logic [1:0] op, input int i, input logic [7:0] d);
    case (i)
      0, 3: return (op == 2'b00 && i == 3) ? d : 8'hAA;
      1, 4: return 8'h55;
      2: return (op == 2'b00) ? 8'hA0 : 8'h80;
      default: return op[1] ? 8'h10 : 8'h30;
    endcase
  endfunction

  task automatic run_op(input vec_t v, input bit inject);
    int   cyc;
    logic prev_oe;
    int   nw;
    @(negedge clk);
    m_clear = 1'b1;
    m_busy  = int'(v.k);
    m_prog  = (v.op == 2'b00);
    m_final = (v.op == 2'b00) ? v.data : 8'hFF;
    m_expw  = (v.op == 2'b00) ? 4 : 6;
    @(negedge clk);
    m_clear    = 1'b0;
    req_op     = v.op;
    req_toggle = v.tog;
    req_addr   = v.addr;
    req_data   = v.data;
    req_valid  = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R10", "ready after accept", req_ready, 0);
    cyc = 0;
    prev_oe = fl_oe_n;
    while (!(done || err) && cyc < 3000) begin
      if (inject && cyc == 5) begin
        req_valid = 1'b1;
        req_op    = 2'b10;
        req_data  = ~v.data;
        req_addr  = 19'h00777;
      end
      if (inject && cyc == 8) req_valid = 1'b0;
      prev_oe = fl_oe_n;
      @(negedge clk);
      cyc++;
    end
    // R8 result kind and R9 timing/returned byte
    chk(done == !v.eerr, "R8", "done", done, !v.eerr);
    chk(err == v.eerr, "R8", "err", err, v.eerr);
    chk(!prev_oe && fl_oe_n, "R9", "result cycle after read", prev_oe, 0);
    chk(last_read == v.elast, "R9", "last_read", last_read, v.elast);
    if (v.tog)
      chk(m_reads == int'(v.ereads), "R7", "toggle read count", m_reads, v.ereads);
    else if (v.op == 2'b00)
      chk(m_reads == int'(v.ereads), "R5", "program poll read count", m_reads, v.ereads);
    else
      chk(m_reads == int'(v.ereads), "R6", "erase poll read count", m_reads, v.ereads);
    nw = (v.op == 2'b00) ? 4 : 6;
    chk(m_nw == nw, (v.op == 2'b00) ? "R1" : "R2", "write count", m_nw, nw);
    for (int i = 0; i < nw && i < 8; i++) begin
      chk(log_a[i] == exp_wa(v.op, i, v.addr), (v.op == 2'b00) ? "R1" : "R2", "write addr",
          int'(log_a[i]), int'(exp_wa(v.op, i, v.addr)));
      chk(log_d[i] == exp_wd(v.op, i, v.data), (v.op == 2'b00) ? "R1" : "R2", "write data",
          log_d[i], exp_wd(v.op, i, v.data));
      chk(log_w[i] == 3, "R3", "strobe width", log_w[i], 3);
    end
    chk(oe_bad == 0 && early == 0 && clash == 0, "R4", "read shape", oe_bad + early + clash, 0);
    @(negedge clk);
    chk(req_ready && !done && !err, "R10", "ready after result", req_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(req_ready, "R11", "ready in reset", req_ready, 1);
    chk(fl_ce_n && fl_we_n && fl_oe_n, "R11", "strobes in reset", {fl_ce_n, fl_we_n, fl_oe_n}, 7);
    chk(!fl_wdrive && !done && !err, "R11", "drive/result in reset", {fl_wdrive, done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_op(VECS[i], 1'b0);

    // R10: request pulsed while busy is ignored
    run_op(VECS[0], 1'b1);

    // R3: strobe clamped to exceed 5 ns at a 2 ns clock
    @(negedge clk);
    v1_valid = 1'b1;
    @(negedge clk);
    v1_valid = 1'b0;
    chk(!v1_we_n, "R3", "strobe starts cycle after accept", v1_we_n, 0);
    w = 0;
    while (!v1_we_n && w < 20) begin
      w++;
      @(negedge clk);
    end
    chk(w == 3, "R3", "clamped strobe width", w, 3);
    w = 0;
    while (!v1_done && !v1_err && w < 200) begin
      w++;
      @(negedge clk);
    end
    chk(v1_done, "R5", "clamped instance completes", v1_done, 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule